// File: doc/BRIEF.md
# Script Processor Run Controller

This block decides when a script-executing fetch engine may run. It keeps the address of the next instruction and requests a fetch from that address. It advances the address by one instruction size when the engine reports that an instruction has finished. It stops the engine when an interrupt condition appears. A host programs it through a small byte-wide register interface. That interface covers a control register, a mode register, two status registers and a separate pointer load port.

There are two ways to gate execution. With the manual-start mode bit set, the engine stays idle until the host writes the start bit. After that it runs freely until an interrupt halts it. With manual start off, loading a new pointer while idle starts fetching on its own. With the single-step bit set, the controller halts after every instruction and raises a step interrupt. The host must then read both status registers, which acknowledges and clears the interrupt. Only after that does a start write resume execution.

The interrupt output is active low and comes as a data/output-enable pair. An open-drain style drives only while the interrupt is asserted. A push-pull style always drives. A disable bit holds the output inactive.

Top module: `scr_run_ctrl`

## Requirements
- R1: When an instruction completes while the single-step bit (control bit 4) is set, the controller halts, stops requesting fetches and sets the step-pending flag.
- R2: When an instruction completes with single-step clear and no instruction interrupt, a new fetch is requested in the next cycle from the previous address plus INSTR_BYTES.
- R3: A fetch request presents the instruction pointer on fetch_addr and is held, with a stable address, until fetch_done is seen.
- R4: With the manual-start bit (mode bit 0) set, an idle controller ignores pointer loads and starts only on a write with control bit 2 set. Once started, it keeps fetching without further starts until an interrupt.
- R5: With manual start clear, a pointer load while idle starts a fetch from the loaded address in the next cycle.
- R6: While halted with an interrupt pending, start writes are ignored. The pending flags clear once both status registers (address 2 and address 3) have been read, in either order, after the interrupt was raised. A later start resumes fetching at the current pointer.
- R7: An instruction completing with exec_int high halts the controller and sets the exception-pending flag, whether or not single-step is set.
- R8: While the disable bit (control bit 1) is set, irq_n_o stays high.
- R9: With the driver-style bit (control bit 3) clear, which is its reset value, irq_oe_o is high only while the interrupt is asserted. With it set, irq_oe_o is always high. irq_n_o is low exactly when an interrupt is pending and not disabled.
- R10: After reset the control, mode and status registers read zero. The control register (address 0) reads back bits 4, 3 and 1 as written and bit 2 always as zero. The mode register (address 1) reads back only bit 0.
- R11: Pointer loads are accepted while idle or halted and ignored while fetching or executing.
- R12: Status register at address 2 reports any-pending in bit 0, step-pending in bit 1 and halted in bit 2. Status register at address 3 reports exception-pending in bit 2 and step-pending in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (status reads acknowledge interrupts) |
| reg_addr | input | 2 | Register address: 0 control, 1 mode, 2 and 3 status |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |
| ptr_we | input | 1 | Instruction pointer load strobe |
| ptr_wdata | input | PTR_W | Instruction pointer load value |
| fetch_req | output | 1 | Request to fetch the instruction at fetch_addr |
| fetch_addr | output | PTR_W | Current instruction pointer |
| fetch_done | input | 1 | Engine has taken the instruction |
| exec_done | input | 1 | Engine has finished executing the instruction |
| exec_int | input | 1 | The finishing instruction raises an interrupt (valid with exec_done) |
| irq_n_o | output | 1 | Active-low interrupt data |
| irq_oe_o | output | 1 | Interrupt output enable |

## Verification
On every cycle the assertions check the sequencer's local rules. These are halting on a step or an instruction interrupt, advancing by one instruction size and holding a fetch address until it is taken. They also check that start has no effect while an interrupt is pending, that pointer loads are locked out while running, that manual mode stays idle without a start, and the pin rules for the disable and driver-style bits. Only the bench's scenarios can show the longer sequences. These include the two-read acknowledge in both orders, resuming at the right address after a halt, continuous manual-mode runs across several instructions, and the field layout of each register.

// File: rtl/scr_run_pkg.sv
package scr_run_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_HALT  = 2'd3
  } run_state_t;

  // control register bit positions
  localparam int CTL_SSTEP = 4;
  localparam int CTL_DRVPP = 3;
  localparam int CTL_START = 2;
  localparam int CTL_IDIS  = 1;
  // mode register
  localparam int MODE_MANUAL = 0;
  // status register A
  localparam int SA_ANY  = 0;
  localparam int SA_STEP = 1;
  localparam int SA_HALT = 2;
  // status register B
  localparam int SB_EXC  = 2;
  localparam int SB_STEP = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STSA = 2'd2;
  localparam logic [1:0] A_STSB = 2'd3;

  // interrupt is visible on the pin when pending and not disabled
  function automatic logic irq_visible(input logic pend, input logic dis);
    return pend & ~dis;
  endfunction

  // returns {output_enable, active_low_data}
  function automatic logic [1:0] pin_drive(input logic active, input logic pushpull);
    return {pushpull | active, ~active};
  endfunction

endpackage

// File: rtl/scr_run_regs.sv
module scr_run_regs
  import scr_run_pkg::*;
#(
  parameter int PTR_W       = 16,
  parameter int INSTR_BYTES = 8,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             ptr_open,
  input  logic             ptr_adv,
  input  logic             step_evt,
  input  logic             exc_evt,
  input  logic             halted,
  output logic [PTR_W-1:0] ptr_q,
  output logic             sstep_q,
  output logic             drvpp_q,
  output logic             idis_q,
  output logic             manual_q,
  output logic             start_pls,
  output logic             ptr_load_pls,
  output logic             step_pend,
  output logic             exc_pend,
  output logic             pend_any,
  output logic             ack_done
);

  localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(INSTR_BYTES);

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return p + PTR_STEP;
  endfunction

  logic wr_ctrl, wr_mode, rd_sa, rd_sb;
  logic seen_a, seen_b, seen_a_nx, seen_b_nx;
  logic unused_wbits;

  assign wr_ctrl      = reg_we && (reg_addr == A_CTRL);
  assign wr_mode      = reg_we && (reg_addr == A_MODE);
  assign rd_sa        = reg_re && (reg_addr == A_STSA);
  assign rd_sb        = reg_re && (reg_addr == A_STSB);
  assign start_pls    = wr_ctrl && reg_wdata[CTL_START];
  assign ptr_load_pls = ptr_we && ptr_open;
  assign pend_any     = step_pend | exc_pend;
  assign unused_wbits = ^reg_wdata;

  // control and mode bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sstep_q  <= 1'b0;
      drvpp_q  <= 1'b0;
      idis_q   <= 1'b0;
      manual_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sstep_q <= reg_wdata[CTL_SSTEP];
        drvpp_q <= reg_wdata[CTL_DRVPP];
        idis_q  <= reg_wdata[CTL_IDIS];
      end
      if (wr_mode) manual_q <= reg_wdata[MODE_MANUAL];
    end
  end

  // instruction pointer: loads only while stopped, advances after each instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr_q <= '0;
    else if (ptr_load_pls) ptr_q <= ptr_wdata;
    else if (ptr_adv)      ptr_q <= advance(ptr_q);
  end

  // acknowledge tracking: both status registers must be read after the event
  always_comb begin
    seen_a_nx = seen_a | (rd_sa & pend_any);
    seen_b_nx = seen_b | (rd_sb & pend_any);
    ack_done  = pend_any & seen_a_nx & seen_b_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_pend <= 1'b0;
      exc_pend  <= 1'b0;
      seen_a    <= 1'b0;
      seen_b    <= 1'b0;
    end else if (step_evt || exc_evt) begin
      step_pend <= step_pend | step_evt;
      exc_pend  <= exc_pend | exc_evt;
      seen_a    <= 1'b0;
      seen_b    <= 1'b0;
    end else if (ack_done) begin
      step_pend <= 1'b0;
      exc_pend  <= 1'b0;
      seen_a    <= 1'b0;
      seen_b    <= 1'b0;
    end else begin
      seen_a <= seen_a_nx;
      seen_b <= seen_b_nx;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTL_SSTEP] = sstep_q;
        reg_rdata[CTL_DRVPP] = drvpp_q;
        reg_rdata[CTL_IDIS]  = idis_q;
      end
      A_MODE: reg_rdata[MODE_MANUAL] = manual_q;
      A_STSA: begin
        reg_rdata[SA_ANY]  = pend_any;
        reg_rdata[SA_STEP] = step_pend;
        reg_rdata[SA_HALT] = halted;
      end
      A_STSB: begin
        reg_rdata[SB_EXC]  = exc_pend;
        reg_rdata[SB_STEP] = step_pend;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/scr_run_fsm.sv
module scr_run_fsm
  import scr_run_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_pls,
  input  logic       ptr_load_pls,
  input  logic       manual,
  input  logic       sstep,
  input  logic       pend_any,
  input  logic       fetch_done,
  input  logic       exec_done,
  input  logic       exec_int,
  output run_state_t state,
  output logic       fetch_req,
  output logic       ptr_adv,
  output logic       step_evt,
  output logic       exc_evt,
  output logic       ptr_open,
  output logic       halted
);

  run_state_t nxt;

  always_comb begin
    nxt      = state;
    ptr_adv  = 1'b0;
    step_evt = 1'b0;
    exc_evt  = 1'b0;
    unique case (state)
      ST_IDLE:
        if (start_pls || (ptr_load_pls && !manual)) nxt = ST_FETCH;
      ST_FETCH:
        if (fetch_done) nxt = ST_EXEC;
      ST_EXEC:
        if (exec_done) begin
          ptr_adv  = 1'b1;
          step_evt = sstep;
          exc_evt  = exec_int;
          nxt      = (sstep || exec_int) ? ST_HALT : ST_FETCH;
        end
      ST_HALT:
        if (start_pls && !pend_any) nxt = ST_FETCH;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign fetch_req = (state == ST_FETCH);
  assign halted    = (state == ST_HALT);
  assign ptr_open  = (state == ST_IDLE) || (state == ST_HALT);

endmodule

// File: rtl/scr_run_irq_out.sv
module scr_run_irq_out
  import scr_run_pkg::*;
(
  input  logic pend_any,
  input  logic idis,
  input  logic drvpp,
  output logic irq_active,
  output logic irq_oe_o,
  output logic irq_n_o
);

  assign irq_active            = irq_visible(pend_any, idis);
  assign {irq_oe_o, irq_n_o}   = pin_drive(irq_active, drvpp);

endmodule

// File: rtl/scr_run_ctrl.sv
module scr_run_ctrl
  import scr_run_pkg::*;
#(
  parameter int PTR_W       = 16,
  parameter int INSTR_BYTES = 8,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  output logic             fetch_req,
  output logic [PTR_W-1:0] fetch_addr,
  input  logic             fetch_done,
  input  logic             exec_done,
  input  logic             exec_int,
  output logic             irq_n_o,
  output logic             irq_oe_o
);

  // named internal events, also observed by the checker
  run_state_t       state;
  logic [PTR_W-1:0] ptr_q;
  logic sstep_q, drvpp_q, idis_q, manual_q;
  logic start_pls, ptr_load_pls, ptr_adv, ptr_open, halted;
  logic step_evt, exc_evt, step_pend, exc_pend, pend_any, ack_done;
  logic irq_active;

  scr_run_regs #(
    .PTR_W(PTR_W), .INSTR_BYTES(INSTR_BYTES), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ptr_open(ptr_open), .ptr_adv(ptr_adv),
    .step_evt(step_evt), .exc_evt(exc_evt), .halted(halted),
    .ptr_q(ptr_q), .sstep_q(sstep_q), .drvpp_q(drvpp_q),
    .idis_q(idis_q), .manual_q(manual_q),
    .start_pls(start_pls), .ptr_load_pls(ptr_load_pls),
    .step_pend(step_pend), .exc_pend(exc_pend),
    .pend_any(pend_any), .ack_done(ack_done)
  );

  scr_run_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_pls(start_pls), .ptr_load_pls(ptr_load_pls),
    .manual(manual_q), .sstep(sstep_q), .pend_any(pend_any),
    .fetch_done(fetch_done), .exec_done(exec_done), .exec_int(exec_int),
    .state(state), .fetch_req(fetch_req), .ptr_adv(ptr_adv),
    .step_evt(step_evt), .exc_evt(exc_evt),
    .ptr_open(ptr_open), .halted(halted)
  );

  scr_run_irq_out u_irq (
    .pend_any(pend_any), .idis(idis_q), .drvpp(drvpp_q),
    .irq_active(irq_active), .irq_oe_o(irq_oe_o), .irq_n_o(irq_n_o)
  );

  assign fetch_addr = ptr_q;

endmodule

// File: rtl/scr_run_ctrl_chk.sv
module scr_run_ctrl_chk
  import scr_run_pkg::*;
#(
  parameter int PTR_W       = 16,
  parameter int INSTR_BYTES = 8,
  parameter int REG_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input run_state_t       state,
  input logic             sstep_q,
  input logic             drvpp_q,
  input logic             idis_q,
  input logic             manual_q,
  input logic             start_pls,
  input logic             step_pend,
  input logic             exc_pend,
  input logic             pend_any,
  input logic             reg_re,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_rdata,
  input logic             ptr_we,
  input logic             fetch_req,
  input logic [PTR_W-1:0] fetch_addr,
  input logic             fetch_done,
  input logic             exec_done,
  input logic             exec_int,
  input logic             irq_n_o,
  input logic             irq_oe_o
);

  p_step_halts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && exec_done && sstep_q) |=> (state == ST_HALT && step_pend && !fetch_req));

  p_free_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && exec_done && !sstep_q && !exec_int)
      |=> (fetch_req && fetch_addr == $past(fetch_addr) + PTR_W'(INSTR_BYTES)));

  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_done) |=> (fetch_req && $stable(fetch_addr)));

  p_manual_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && manual_q && !start_pls) |=> (state == ST_IDLE));

  p_pend_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && pend_any) |=> !fetch_req);

  p_exc_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && exec_done && exec_int) |=> (state == ST_HALT && exc_pend));

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idis_q |-> irq_n_o);

  p_open_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!drvpp_q && irq_n_o) |-> !irq_oe_o);

  p_push_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drvpp_q |-> irq_oe_o);

  p_start_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == A_CTRL) |-> !reg_rdata[CTL_START]);

  p_ptr_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && (state == ST_FETCH || (state == ST_EXEC && !exec_done))) |=> $stable(fetch_addr));

endmodule

bind scr_run_ctrl scr_run_ctrl_chk #(
  .PTR_W(PTR_W), .INSTR_BYTES(INSTR_BYTES), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state),
  .sstep_q(sstep_q), .drvpp_q(drvpp_q), .idis_q(idis_q), .manual_q(manual_q),
  .start_pls(start_pls), .step_pend(step_pend), .exc_pend(exc_pend),
  .pend_any(pend_any), .reg_re(reg_re), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ptr_we(ptr_we), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .fetch_done(fetch_done), .exec_done(exec_done), .exec_int(exec_int),
  .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
);

// File: tb/scr_run_ctrl_test.sv
`timescale 1ns/1ps
module scr_run_ctrl_test;

  localparam int PTR_W = 16;
  localparam int STEP  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic             ptr_we = 1'b0;
  logic [PTR_W-1:0] ptr_wdata = '0;
  logic             fetch_req;
  logic [PTR_W-1:0] fetch_addr;
  logic             fetch_done = 1'b0, exec_done = 1'b0, exec_int = 1'b0;
  logic             irq_n_o, irq_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  scr_run_ctrl #(.PTR_W(PTR_W), .INSTR_BYTES(STEP), .REG_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_done(fetch_done), .exec_done(exec_done),
    .exec_int(exec_int), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input int ss, input int drv, input int st, input int dis);
    return 8'(ss * 16 + drv * 8 + st * 4 + dis * 2);
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic load_ptr(input logic [PTR_W-1:0] v);
    ptr_we = 1'b1; ptr_wdata = v;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic take_fetch();
    fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0;
  endtask

  task automatic finish_instr(input logic intr);
    exec_done = 1'b1; exec_int = intr;
    @(negedge clk);
    exec_done = 1'b0; exec_int = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [PTR_W-1:0] a;
    do_reset();

    // R10 reset values
    rd(2'd0, d); chk("R10 ctrl reset", d, 0);
    rd(2'd1, d); chk("R10 mode reset", d, 0);
    rd(2'd2, d); chk("R10 status A reset", d, 0);
    rd(2'd3, d); chk("R10 status B reset", d, 0);
    chk("R9 oe released at reset", irq_oe_o, 0);
    chk("R9 irq_n high at reset", irq_n_o, 1);
    chk("R10 no fetch at reset", fetch_req, 0);

    // R10 readback sweep of control bits, start never set here
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, ctl(v / 4, (v / 2) % 2, 0, v % 2));
      rd(2'd0, d); chk("R10 ctrl readback", d, ctl(v / 4, (v / 2) % 2, 0, v % 2));
    end
    wr(2'd0, 8'h00);
    chk("R10 no fetch from plain ctrl writes", fetch_req, 0);

    // R5 auto start from pointer load
    load_ptr(16'h0040);
    chk("R5 autostart fetch_req", fetch_req, 1);
    chk("R5 autostart address", fetch_addr, 16'h0040);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 fetch held", fetch_req, 1);
      chk("R3 address held", fetch_addr, 16'h0040);
    end
    take_fetch();
    chk("R3 fetch drops when taken", fetch_req, 0);
    load_ptr(16'h0099);
    chk("R11 load ignored while executing", fetch_addr, 16'h0040);
    finish_instr(1'b0);
    chk("R2 next fetch requested", fetch_req, 1);
    chk("R2 next address", fetch_addr, 16'h0040 + STEP);
    load_ptr(16'h0077);
    chk("R11 load ignored while fetching", fetch_addr, 16'h0040 + STEP);
    take_fetch();
    finish_instr(1'b1);
    chk("R7 halt on exec_int", fetch_req, 0);
    chk("R9 open drain drives when asserted", irq_oe_o, 1);
    chk("R9 irq_n low when asserted", irq_n_o, 0);
    wr(2'd0, ctl(0, 0, 1, 0));
    chk("R6 start ignored while pending", fetch_req, 0);
    rd(2'd2, d); chk("R12 status A with exception", d, 8'h05);
    chk("R6 still pending after one read", irq_n_o, 0);
    wr(2'd0, ctl(0, 0, 1, 0));
    chk("R6 start ignored after one read", fetch_req, 0);
    rd(2'd3, d); chk("R12 status B with exception", d, 8'h04);
    chk("R6 cleared after both reads", irq_n_o, 1);
    chk("R9 open drain released when idle", irq_oe_o, 0);
    rd(2'd2, d); chk("R12 status A halted only", d, 8'h04);
    wr(2'd0, ctl(0, 0, 1, 0));
    chk("R6 resume fetch", fetch_req, 1);
    chk("R6 resume address", fetch_addr, 16'h0040 + 2 * STEP);

    // R1 single step, acknowledging in reverse order
    wr(2'd0, ctl(1, 0, 0, 0));
    for (int k = 0; k < 3; k++) begin
      a = 16'(16'h0040 + (2 + k) * STEP);
      chk("R1 step fetch address", fetch_addr, a);
      take_fetch();
      finish_instr(1'b0);
      chk("R1 halted after step", fetch_req, 0);
      chk("R1 step irq asserted", irq_n_o, 0);
      rd(2'd3, d); chk("R12 status B step", d, 8'h08);
      rd(2'd2, d); chk("R12 status A step", d, 8'h07);
      chk("R6 cleared in reverse order", irq_n_o, 1);
      wr(2'd0, ctl(1, 0, 1, 0));
      chk("R1 restart after step", fetch_req, 1);
    end
    take_fetch();
    finish_instr(1'b0);

    // R8 R9 pin sweep with a step interrupt pending, then with none
    for (int p = 1; p >= 0; p--) begin
      for (int v = 0; v < 4; v++) begin
        wr(2'd0, ctl(1, v / 2, 0, v % 2));
        chk("R9 output enable", irq_oe_o, ((v / 2) == 1) || (p == 1 && (v % 2) == 0));
        chk("R8 irq data", irq_n_o, !(p == 1 && (v % 2) == 0));
      end
      if (p == 1) begin
        rd(2'd2, d);
        rd(2'd3, d);
      end
    end
    wr(2'd0, 8'h00);
    load_ptr(16'h0300);
    chk("R11 load accepted while halted", fetch_addr, 16'h0300);
    chk("R11 halted load does not start", fetch_req, 0);

    // R4 manual start mode
    do_reset();
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R10 mode reads bit 0 only", d, 8'h01);
    load_ptr(16'h0020);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 no autostart in manual mode", fetch_req, 0);
    end
    wr(2'd0, ctl(0, 0, 1, 0));
    chk("R4 start begins fetch", fetch_req, 1);
    chk("R3 fetch from pointer", fetch_addr, 16'h0020);
    for (int k = 0; k < 4; k++) begin
      take_fetch();
      finish_instr(1'b0);
      chk("R4 continues without start", fetch_req, 1);
      chk("R4 continuing address", fetch_addr, 16'(16'h0020 + (k + 1) * STEP));
    end
    take_fetch();
    finish_instr(1'b1);
    chk("R4 stops on interrupt", fetch_req, 0);
    rd(2'd2, d);
    rd(2'd3, d);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R4 stays halted without start", fetch_req, 0);
    end
    load_ptr(16'h0500);
    wr(2'd0, ctl(0, 0, 1, 0));
    chk("R6 start after ack", fetch_req, 1);
    chk("R11 resumes at loaded pointer", fetch_addr, 16'h0500);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule